// File: doc/BRIEF.md
# Device Life-Cycle Mode Controller

This block turns fuse word 0 into the device's life-cycle mode and derives from that mode the access rights of three register regions and a set of debug enable lines. It watches the completion strobe of the fuse read engine. Each time word 0 finishes reading, during the load after reset or through a later software read, the mode is recomputed from the word's close bit and the read's error and disturbance flags. Reads of any other word leave the mode alone.

The mode is one of open, closed or invalid. Programming the close bit of word 0 moves an open device to closed. A word 0 read that reports an error or a disturbance marks the word as tampered with. The device then enters invalid, the end-of-life mode that locks the upper shadows away even from secure software. Invalid is left only through the asynchronous power-on reset. Before word 0 has been read, the block holds the restrictive closed mode.

The region permissions are given as two 6-bit vectors, one for secure and one for non-secure accesses. The debug lines are high only in open mode.

Top module: `lc_state_ctrl`

## Requirements
- R1: After reset, and until word 0 is first read, mode is 2'b01 (closed), dbg_en is all zero, ns_perm is 6'h05 and s_perm is 6'h3F.
- R2: A word 0 read (rd_done high, rd_addr zero) with rd_err and rd_dist low and rd_data bit 6 clear sets mode to 2'b00 (open) on the next clock, unless the mode is invalid.
- R3: A word 0 read with rd_err and rd_dist low and rd_data bit 6 set sets mode to 2'b01 (closed) on the next clock, unless the mode is invalid.
- R4: A word 0 read with rd_err or rd_dist high sets mode to 2'b11 (invalid) on the next clock.
- R5: Once the mode is invalid, it stays invalid whatever is read, until rst_n is asserted. Asserting rst_n returns the mode to closed at once.
- R6: A completed read of any word other than word 0 leaves the mode unchanged, whatever its data, error or disturbance flags.
- R7: Permission bits are [0] control read, [1] control write, [2] lower-shadow read, [3] lower-shadow write, [4] upper-shadow read and [5] upper-shadow write. In open mode, ns_perm and s_perm are both 6'h3F. In closed mode, ns_perm is 6'h05 and s_perm is 6'h3F. In invalid mode, ns_perm is 6'h01 and s_perm is 6'h05.
- R8: Every dbg_en line is high in open mode and low in the closed and invalid modes.
- R9: While rd_done is low, no change on rd_addr, rd_data, rd_err or rd_dist alters the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asserted asynchronously, released synchronously inside the block |
| rd_done | input | 1 | One-cycle strobe: a fuse word read has completed |
| rd_addr | input | ADDR_W (7) | Index of the word that was read |
| rd_data | input | DATA_W (32) | Value of the word that was read |
| rd_err | input | 1 | The read reported an uncorrectable error |
| rd_dist | input | 1 | The read reported a disturbance |
| mode | output | 2 | Life-cycle mode: 00 open, 01 closed, 11 invalid |
| ns_perm | output | 6 | Region permissions for non-secure accesses |
| s_perm | output | 6 | Region permissions for secure accesses |
| dbg_en | output | DBG_W (4) | Debug enable lines |

## Verification
The hardest situations to reach are those that should change nothing. These include a tampered word 0 read while the device is already invalid, and a read of a neighbouring word that carries the close bit or error flags. In both cases a faulty design shows itself only in a later cycle. The stimulus first walks the mode through open, closed and open again. It then sends error-flagged and close-bit reads of non-zero words, and strobe-free pulses on address 0, and compares the outputs against the model on every clock. Finally it drives the device into invalid, tries good reads with both close-bit values, and asserts reset in the middle of the run to show that only reset leaves invalid.

// File: rtl/lc_pkg.sv
package lc_pkg;

  typedef enum logic [1:0] {
    LC_OPEN    = 2'b00,
    LC_CLOSED  = 2'b01,
    LC_INVALID = 2'b11
  } lc_mode_e;

  localparam int unsigned PERM_W = 6;

  // permission bit positions
  localparam int unsigned P_CTRL_RD = 0;
  localparam int unsigned P_CTRL_WR = 1;
  localparam int unsigned P_LOW_RD  = 2;
  localparam int unsigned P_LOW_WR  = 3;
  localparam int unsigned P_UP_RD   = 4;
  localparam int unsigned P_UP_WR   = 5;

endpackage

// File: rtl/lc_rst_sync.sv
module lc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/lc_mode_fsm.sv
module lc_mode_fsm
  import lc_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_done,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              close_bit,
  input  logic              rd_err,
  input  logic              rd_dist,
  output lc_mode_e          mode_o
);

  lc_mode_e mode_q, mode_d;
  logic     word0_hit;
  logic     tamper;
  logic     mode_en;

  assign word0_hit = rd_done && (rd_addr == '0);
  assign tamper    = rd_err || rd_dist;
  // clock enable: only a word 0 read outside the terminal mode may update
  assign mode_en   = word0_hit && (mode_q != LC_INVALID);

  always_comb begin
    mode_d = mode_q;
    if (mode_en) begin
      if (tamper)         mode_d = LC_INVALID;
      else if (close_bit) mode_d = LC_CLOSED;
      else                mode_d = LC_OPEN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= LC_CLOSED;
    else if (mode_en) mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  assert_tamper_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && rd_addr == '0 && (rd_err || rd_dist)) |=> (mode_o == LC_INVALID));

  assert_invalid_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == LC_INVALID) |=> (mode_o == LC_INVALID));

  assert_other_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && rd_addr != '0) |=> $stable(mode_o));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_done) |=> $stable(mode_o));

  assert_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && rd_addr == '0 && !rd_err && !rd_dist && close_bit &&
     mode_o != LC_INVALID) |=> (mode_o == LC_CLOSED));

  assert_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && rd_addr == '0 && !rd_err && !rd_dist && !close_bit &&
     mode_o != LC_INVALID) |=> (mode_o == LC_OPEN));

endmodule

// File: rtl/lc_perm_map.sv
module lc_perm_map
  import lc_pkg::*;
#(
  parameter int unsigned DBG_W = 4
) (
  input  lc_mode_e          mode_i,
  output logic [PERM_W-1:0] ns_perm,
  output logic [PERM_W-1:0] s_perm,
  output logic [DBG_W-1:0]  dbg_en
);

  logic is_open;
  logic is_invalid;

  assign is_open    = (mode_i == LC_OPEN);
  assign is_invalid = (mode_i == LC_INVALID);

  always_comb begin
    // control and lower-shadow reads stay available except noted
    ns_perm            = '0;
    ns_perm[P_CTRL_RD] = 1'b1;
    ns_perm[P_CTRL_WR] = is_open;
    ns_perm[P_LOW_RD]  = !is_invalid;
    ns_perm[P_LOW_WR]  = is_open;
    ns_perm[P_UP_RD]   = is_open;
    ns_perm[P_UP_WR]   = is_open;

    s_perm             = '0;
    s_perm[P_CTRL_RD]  = 1'b1;
    s_perm[P_CTRL_WR]  = !is_invalid;
    s_perm[P_LOW_RD]   = 1'b1;
    s_perm[P_LOW_WR]   = !is_invalid;
    s_perm[P_UP_RD]    = !is_invalid;
    s_perm[P_UP_WR]    = !is_invalid;
  end

  for (genvar g = 0; g < DBG_W; g++) begin : g_dbg
    assign dbg_en[g] = is_open;
  end

endmodule

// File: rtl/lc_state_ctrl.sv
module lc_state_ctrl
  import lc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CLOSE_BIT   = 6,
  parameter int unsigned DBG_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_done,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_err,
  input  logic              rd_dist,
  output logic [1:0]        mode,
  output logic [5:0]        ns_perm,
  output logic [5:0]        s_perm,
  output logic [DBG_W-1:0]  dbg_en
);

  logic     rst_sync_n;
  lc_mode_e mode_w;
  logic     unused_data;

  assign unused_data = ^rd_data;

  lc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lc_mode_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_done   (rd_done),
    .rd_addr   (rd_addr),
    .close_bit (rd_data[CLOSE_BIT]),
    .rd_err    (rd_err),
    .rd_dist   (rd_dist),
    .mode_o    (mode_w)
  );

  lc_perm_map #(.DBG_W(DBG_W)) u_map (
    .mode_i  (mode_w),
    .ns_perm (ns_perm),
    .s_perm  (s_perm),
    .dbg_en  (dbg_en)
  );

  assign mode = mode_w;

  assert_dbg_locked_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode != 2'b00) |-> (dbg_en == '0));

  assert_upper_ns_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode != 2'b00) |-> (!ns_perm[4] && !ns_perm[5]));

  assert_invalid_secure_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == 2'b11) |-> (!s_perm[4] && !s_perm[5] && !ns_perm[2]));

endmodule

// File: tb/lc_state_ctrl_tb.sv
module lc_state_ctrl_tb_top;

  localparam int ADDR_W = 7;
  localparam int DATA_W = 32;
  localparam int DBG_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              rd_done;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              rd_err;
  logic              rd_dist;
  logic [1:0]        mode;
  logic [5:0]        ns_perm;
  logic [5:0]        s_perm;
  logic [DBG_W-1:0]  dbg_en;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  // reference model state: 0 open, 1 closed, 3 invalid
  int ref_mode;

  always #10 clk = ~clk;

  lc_state_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .rd_done(rd_done), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_err(rd_err), .rd_dist(rd_dist),
    .mode(mode), .ns_perm(ns_perm), .s_perm(s_perm), .dbg_en(dbg_en)
  );

  task automatic check(input string req);
    logic [1:0]       em;
    logic [5:0]       ens, es;
    logic [DBG_W-1:0] ed;
    em  = 2'(ref_mode);
    ens = (ref_mode == 0) ? 6'h3F : (ref_mode == 1) ? 6'h05 : 6'h01;
    es  = (ref_mode == 3) ? 6'h05 : 6'h3F;
    ed  = (ref_mode == 0) ? '1 : '0;
    checks++;
    if (mode !== em || ns_perm !== ens || s_perm !== es || dbg_en !== ed) begin
      errors++;
      $display("FAIL %s: mode=%b ns=%h s=%h dbg=%b expected mode=%b ns=%h s=%h dbg=%b",
               req, mode, ns_perm, s_perm, dbg_en, em, ens, es, ed);
    end
  endtask

  // called at a negedge: drive inputs, advance one clock, update model, compare
  task automatic cyc(input bit d, input int a, input bit cb, input bit e,
                     input bit di, input string req);
    rd_done = d;
    rd_addr = ADDR_W'(a);
    rd_data = 32'hA5A5_0000 | (cb ? 32'h40 : 32'h0);
    rd_err  = e;
    rd_dist = di;
    @(posedge clk);
    if (d && a == 0 && ref_mode != 3) begin
      if (e || di) ref_mode = 3;
      else if (cb) ref_mode = 1;
      else         ref_mode = 0;
    end
    @(negedge clk);
    check(req);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, req);
  endtask

  initial begin
    rst_n = 1'b0; rd_done = 0; rd_addr = '0; rd_data = '0; rd_err = 0; rd_dist = 0;
    ref_mode = 1;
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    idle(4, "R1 hold before word0");
    cyc(0, 0, 1, 1, 1, "R9 no strobe");
    cyc(1, 0, 0, 0, 0, "R2 open");
    cyc(1, 5, 1, 0, 0, "R6 close bit other word");
    cyc(1, 1, 0, 1, 0, "R6 error other word");
    cyc(1, 127, 0, 0, 1, "R6 disturb other word");
    cyc(0, 0, 1, 1, 0, "R9 no strobe open");
    cyc(1, 0, 1, 0, 0, "R3 close");
    cyc(1, 0, 0, 0, 0, "R2 reopen");
    cyc(1, 0, 1, 0, 0, "R3 close again");
    cyc(1, 0, 1, 0, 1, "R4 disturb");
    cyc(1, 0, 0, 0, 0, "R5 good open read in invalid");
    cyc(1, 0, 1, 0, 0, "R5 good close read in invalid");
    cyc(1, 0, 0, 1, 0, "R5 error in invalid");
    idle(2, "R5 idle invalid");
    @(negedge clk);
    rst_n = 1'b0;
    ref_mode = 1;
    #1 check("R5 reset leaves invalid");
    @(negedge clk);
    rst_n = 1'b1;
    idle(4, "R1 after reset");
    cyc(1, 0, 0, 1, 0, "R4 error from closed");
    cyc(1, 3, 0, 0, 0, "R6 in invalid");
    idle(2, "R7 invalid perms");
    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule